// File: doc/BRIEF.md
# SHA-256 Message Schedule Generator

This block expands one 512-bit message block into the 64 schedule words that the SHA-256 compression rounds consume. The block is loaded in one cycle with all sixteen 32-bit message words. After that it presents one schedule word at a time, each with its index. A consumer moves it to the next word with an advance strobe. Words are produced on the fly while the rounds run, so no 64-entry table is ever stored.

Sixteen window registers hold the most recent words. The four-term sum for each new word goes through two carry-save stages. The carry-save pair is then registered, and a single carry-propagate adder finishes it on the next advance. As a result, no combinational path holds more than one full-width carry chain. A new word is ready on every cycle, so a consumer that advances every cycle sees a fresh word every cycle.

A compressor built around the same retiming consumes each word a few rounds ahead of its own round counter. It reads the word by index, so the lead is handled on its side.

Top module: `wsched_top`

## Requirements
- R1: While reset (`rstN` low) is applied and in the cycle after it, `wValid` is low.
- R2: In the cycle after `loadEn` is sampled high, `wValid` is high, `wIdx` is 0 and `wOut` equals message word 0. Message word i sits at `blockIn[511-32*i -: 32]`, so word 0 is bits 511:480.
- R3: Words with index 0 to 15 equal message words 0 to 15, in that order.
- R4: Words with index 16 to 63 equal sig1(W[t-2]) + W[t-7] + sig0(W[t-15]) + W[t-16], taken modulo 2^32. Here sig0(x) = rotr(x,7) ^ rotr(x,18) ^ (x>>3) and sig1(x) = rotr(x,17) ^ rotr(x,19) ^ (x>>10).
- R5: When `advance` is high while `wValid` is high, the next cycle shows the following word with `wIdx` one higher. When `advance` is low, `wOut` and `wIdx` hold.
- R6: Exactly 64 words are valid per block. Advancing from index 63 drops `wValid`, and further `advance` pulses leave `wValid` low until the next load.
- R7: A load while words are still streaming abandons the old block. The next cycle shows word 0 of the new block, and its full schedule follows.
- R8: When `loadEn` and `advance` are high in the same cycle, the load wins.
- R9: Advancing on every cycle yields a new correct word every cycle, with no stall cycles anywhere in the 64.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load the block on `blockIn` and restart at word 0 |
| blockIn | input | 512 | Sixteen message words, word 0 in the top bits |
| advance | input | 1 | Step to the next schedule word |
| wOut | output | 32 | Current schedule word |
| wValid | output | 1 | `wOut` holds a schedule word of the current block |
| wIdx | output | 6 | Index of the word on `wOut` |

## Verification
The first corner is the handoff between message words and generated words, at indices 15 to 17. A window tap or a retiming register that is off by one cycle corrupts W[16] onward while words 0 to 15 still look right. The bench inserts advance gaps at irregular indices. A pipeline register that updates without a shift would then produce wrong later words even though back-to-back streaming passes. The end of the block is checked for an extra word or a missing word. A reload in mid-stream, and a reload on the same cycle as an advance, must restart cleanly with the carry-save pair primed from the new block. A stale pair would show up at W[16].

// File: rtl/wsched_pkg.sv
package wsched_pkg;
  localparam int WORD_W  = 32;
  localparam int DEPTH   = 16;
  localparam int ROUNDS  = 64;
  localparam int BLOCK_W = WORD_W * DEPTH;
  localparam int IDX_W   = $clog2(ROUNDS);

  // window taps relative to the oldest word W[t] of a new W[t+16]
  localparam int TAP_NEAR = DEPTH - 2;
  localparam int TAP_MID  = DEPTH - 7;
  localparam int TAP_FAR  = 1;
  localparam int TAP_OLD  = 0;

  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic load;
    logic shift;
  } schedCtl_t;

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t sigLo(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t sigHi(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction
endpackage

// File: rtl/wsched_csa.sv
module wsched_csa #(
  parameter int W = 32
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  output logic [W-1:0] sumV,
  output logic [W-1:0] carV
);
  assign carV[0] = 1'b0;
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sumV[i] = x[i] ^ y[i] ^ z[i];
    if (i < W - 1) begin : g_car
      assign carV[i+1] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end
  end
endmodule

// File: rtl/wsched_ctrl.sv
module wsched_ctrl
  import wsched_pkg::*;
#(
  parameter int NUM_ROUNDS = ROUNDS,
  localparam int CW = $clog2(NUM_ROUNDS)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          loadEn,
  input  logic          advance,
  output schedCtl_t     ctl,
  output logic          running,
  output logic [CW-1:0] roundCnt
);
  localparam logic [CW-1:0] LAST = CW'(NUM_ROUNDS - 1);

  always_comb begin
    ctl.load  = loadEn;
    ctl.shift = !loadEn && advance && running;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running  <= 1'b0;
      roundCnt <= '0;
    end else if (ctl.load) begin
      running  <= 1'b1;
      roundCnt <= '0;
    end else if (ctl.shift) begin
      if (roundCnt == LAST) begin
        running <= 1'b0;
      end else begin
        roundCnt <= roundCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wsched_dp.sv
module wsched_dp
  import wsched_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  schedCtl_t          ctl,
  input  logic [BLOCK_W-1:0] blockIn,
  output word_t              headWord
);
  word_t msgWord [DEPTH];
  word_t win     [DEPTH];
  word_t pSum, pCar;
  word_t opNear, opMid, opFar, opOld;
  word_t s1a, c1a, s2a, c2a;
  word_t nextWord;

  for (genvar i = 0; i < DEPTH; i++) begin : g_msg
    assign msgWord[i] = blockIn[BLOCK_W-1-i*WORD_W -: WORD_W];
  end

  // operands for the word after the one entering the window next
  always_comb begin
    if (ctl.load) begin
      opNear = msgWord[TAP_NEAR];
      opMid  = msgWord[TAP_MID];
      opFar  = msgWord[TAP_FAR];
      opOld  = msgWord[TAP_OLD];
    end else begin
      opNear = win[TAP_NEAR+1];
      opMid  = win[TAP_MID+1];
      opFar  = win[TAP_FAR+1];
      opOld  = win[TAP_OLD+1];
    end
  end

  wsched_csa #(.W(WORD_W)) u_csaA (
    .x(sigHi(opNear)), .y(opMid), .z(sigLo(opFar)),
    .sumV(s1a), .carV(c1a)
  );

  wsched_csa #(.W(WORD_W)) u_csaB (
    .x(s1a), .y(c1a), .z(opOld),
    .sumV(s2a), .carV(c2a)
  );

  // the only carry-propagate adder, fed by registers
  assign nextWord = pSum + pCar;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pSum <= '0;
      pCar <= '0;
    end else if (ctl.load || ctl.shift) begin
      pSum <= s2a;
      pCar <= c2a;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_win
    word_t shiftIn;
    if (i == DEPTH - 1) begin : g_tail
      assign shiftIn = nextWord;
    end else begin : g_body
      assign shiftIn = win[i+1];
    end
    always_ff @(posedge clk) begin
      if (!rstN) begin
        win[i] <= '0;
      end else if (ctl.load) begin
        win[i] <= msgWord[i];
      end else if (ctl.shift) begin
        win[i] <= shiftIn;
      end
    end
  end

  assign headWord = win[0];
endmodule

// File: rtl/wsched_top.sv
module wsched_top
  import wsched_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               loadEn,
  input  logic [BLOCK_W-1:0] blockIn,
  input  logic               advance,
  output logic [WORD_W-1:0]  wOut,
  output logic               wValid,
  output logic [IDX_W-1:0]   wIdx
);
  schedCtl_t ctl;

  wsched_ctrl #(.NUM_ROUNDS(ROUNDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .advance(advance),
    .ctl(ctl), .running(wValid), .roundCnt(wIdx)
  );

  wsched_dp u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .blockIn(blockIn),
    .headWord(wOut)
  );
endmodule

// File: rtl/wsched_chk.sv
module wsched_chk
  import wsched_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               loadEn,
  input logic [BLOCK_W-1:0] blockIn,
  input logic               advance,
  input logic [WORD_W-1:0]  wOut,
  input logic               wValid,
  input logic [IDX_W-1:0]   wIdx
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ROUNDS - 1);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rstN |=> !wValid);

  assert_load_head_R2: assert property (@(posedge clk) disable iff (!rstN)
    loadEn |=> wValid && wIdx == '0 && wOut == $past(blockIn[BLOCK_W-1 -: WORD_W]));

  assert_step_index_R5: assert property (@(posedge clk) disable iff (!rstN)
    wValid && advance && !loadEn && wIdx != LAST |=> wValid && wIdx == $past(wIdx) + 1'b1);

  assert_hold_word_R5: assert property (@(posedge clk) disable iff (!rstN)
    wValid && !advance && !loadEn |=> wValid && $stable(wOut) && $stable(wIdx));

  assert_block_end_R6: assert property (@(posedge clk) disable iff (!rstN)
    wValid && advance && !loadEn && wIdx == LAST |=> !wValid);

  assert_stay_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !wValid && !loadEn |=> !wValid);
endmodule

bind wsched_top wsched_chk u_chk (
  .clk(clk), .rstN(rstN), .loadEn(loadEn), .blockIn(blockIn),
  .advance(advance), .wOut(wOut), .wValid(wValid), .wIdx(wIdx)
);

// File: tb/sim_wsched_top.sv
`timescale 1ns/1ps
module sim_wsched_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadEn = 1'b0;
  logic [511:0] blockIn = '0;
  logic         advance = 1'b0;
  logic [31:0]  wOut;
  logic         wValid;
  logic [5:0]   wIdx;

  int nChecks = 0;
  int nFails  = 0;
  logic [31:0] expW [64];

  always #2 clk = ~clk;

  wsched_top u0 (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .blockIn(blockIn),
    .advance(advance), .wOut(wOut), .wValid(wValid), .wIdx(wIdx)
  );

  function automatic logic [31:0] rr(input logic [31:0] x, input int n);
    logic [63:0] d;
    d = {x, x} >> n;
    return d[31:0];
  endfunction

  function automatic logic [31:0] smallA(input logic [31:0] x);
    return rr(x, 7) ^ rr(x, 18) ^ (x >> 3);
  endfunction

  function automatic logic [31:0] smallB(input logic [31:0] x);
    return rr(x, 17) ^ rr(x, 19) ^ (x >> 10);
  endfunction

  task automatic model(input logic [511:0] blk);
    for (int t = 0; t < 16; t++) expW[t] = blk[511-32*t -: 32];
    for (int t = 16; t < 64; t++)
      expW[t] = smallB(expW[t-2]) + expW[t-7] + smallA(expW[t-15]) + expW[t-16];
  endtask

  task automatic check(input string req, input logic ok, input logic [63:0] act,
                       input logic [63:0] expv);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic checkWord(input int t);
    string r;
    r = (t < 16) ? "R3" : "R4";
    check(r, wValid === 1'b1 && wIdx === 6'(t) && wOut === expW[t],
          {25'd0, wValid, wIdx, wOut}, {25'd0, 1'b1, 6'(t), expW[t]});
  endtask

  task automatic doLoad(input logic [511:0] blk);
    blockIn = blk;
    loadEn  = 1'b1;
    advance = 1'b0;
    @(negedge clk);
    loadEn = 1'b0;
    model(blk);
    // R2: head of block right after the load
    check("R2", wValid === 1'b1 && wIdx === 6'd0 && wOut === blk[511:480],
          {31'd0, wValid, wOut}, {31'd0, 1'b1, blk[511:480]});
  endtask

  // stream words [0, upto), gapMode inserts idle cycles
  task automatic stream(input int upto, input bit gapMode);
    for (int t = 0; t < upto; t++) begin
      checkWord(t);
      if (gapMode && (t % 7 == 3 || t == 15 || t == 16)) begin
        advance = 1'b0;
        repeat (2) @(negedge clk);
        // R5: no advance, word and index hold
        check("R5", wValid === 1'b1 && wIdx === 6'(t) && wOut === expW[t],
              {26'd0, wIdx, wOut}, {26'd0, 6'(t), expW[t]});
      end
      advance = 1'b1;
      @(negedge clk);
      advance = 1'b0;
    end
  endtask

  task automatic checkEnd();
    // R6: valid falls after word 63 and further advances are ignored
    check("R6", wValid === 1'b0, {63'd0, wValid}, 64'd0);
    advance = 1'b1;
    repeat (3) @(negedge clk);
    advance = 1'b0;
    check("R6", wValid === 1'b0, {63'd0, wValid}, 64'd0);
  endtask

  function automatic logic [511:0] randBlock();
    logic [511:0] b;
    for (int i = 0; i < 16; i++) b[32*i +: 32] = $urandom;
    return b;
  endfunction

  initial begin
    logic [511:0] abc;
    logic [511:0] b2;
    abc = {32'h61626380, 416'd0, 64'h18};
    repeat (3) @(negedge clk);
    // R1: idle under reset
    check("R1", wValid === 1'b0, {63'd0, wValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1", wValid === 1'b0, {63'd0, wValid}, 64'd0);

    // R9: back-to-back streaming of the padded "abc" block
    doLoad(abc);
    stream(64, 1'b0);
    checkEnd();

    doLoad('0);
    stream(64, 1'b1);
    checkEnd();

    doLoad({512{1'b1}});
    stream(64, 1'b0);
    checkEnd();

    for (int k = 0; k < 8; k++) begin
      doLoad(randBlock());
      stream(64, k[0]);
      checkEnd();
    end

    // single-bit blocks, one per word position
    for (int k = 0; k < 16; k++) begin
      doLoad(512'd1 << (32 * k + (k % 32)));
      stream(64, 1'b0);
      checkEnd();
    end

    // R7: reload in mid-stream
    doLoad(randBlock());
    stream(20, 1'b0);
    b2 = randBlock();
    doLoad(b2);
    check("R7", wOut === b2[511:480], {32'd0, wOut}, {32'd0, b2[511:480]});
    stream(64, 1'b0);
    checkEnd();

    // R8: load and advance together, load wins
    doLoad(randBlock());
    stream(9, 1'b0);
    b2 = randBlock();
    blockIn = b2;
    loadEn  = 1'b1;
    advance = 1'b1;
    @(negedge clk);
    loadEn  = 1'b0;
    advance = 1'b0;
    model(b2);
    check("R8", wValid === 1'b1 && wIdx === 6'd0 && wOut === b2[511:480],
          {26'd0, wIdx, wOut}, {26'd0, 6'd0, b2[511:480]});
    stream(64, 1'b1);
    checkEnd();

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule